// File: doc/BRIEF.md
# Double-Latched Programmable Ratio Divider

This block divides an already prescaled clock by a programmable 15-bit ratio N. A presettable down counter runs from N-1 to zero. It raises a one-cycle terminal-count pulse at zero and then reloads itself. A new ratio can be written at any time into a front holding register. A transfer strobe copies that register into a back register that feeds the counter. The strobe is generated inside the block, one cycle after each terminal-count pulse. Because the counter only reloads at terminal count, and the back register only changes just after it, a reload never picks up a half-updated ratio.

A second output toggles on every terminal-count pulse. It carries the divided frequency halved, with a 50 % duty cycle, for routing to a test pin. Ratios below the supported minimum of 17 are raised to 17 as they move into the back register.

Top module: `ratio_divider`

## Requirements
- R1: While `rst_n` is low, `tc_pulse` and `tc_half` are 0. After reset both ratio registers hold 17, so successive pulses are 17 cycles apart until a written ratio takes effect.
- R2: `tc_pulse` is high for exactly one cycle. Two successive pulses are exactly N cycles apart, where N is the unsigned value that governs that period (`wr_ratio[14]` is the MSB with weight 16384, `wr_ratio[0]` the LSB).
- R3: The back register is loaded only at the clock edge that ends the cycle after a `tc_pulse`. The value the front register holds just before that edge sets every period that starts from the following pulse onward. A write made during the pulse cycle itself therefore governs the very next period.
- R4: A write whose strobe is sampled at the same edge as the transfer is not seen by that transfer. It reaches the back register at the following transfer.
- R5: A write never alters the period in progress, nor the period that starts at the next pulse, unless it was made during the pulse cycle.
- R6: A written ratio below 17, including 0, is used as 17.
- R7: The largest ratio, 32767, gives pulses exactly 32767 cycles apart.
- R8: When several writes fall between two transfers, only the last one is transferred.
- R9: `tc_half` changes in the cycle after each `tc_pulse` and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Strobe: capture `wr_ratio` into the front register |
| wr_ratio | input | 15 | New division ratio, MSB first in weight |
| tc_pulse | output | 1 | One-cycle pulse at terminal count |
| tc_half | output | 1 | Terminal-count rate divided by two, for test routing |

## Verification
A ratio write and the internal transfer can fall on the same clock edge. The bench provokes this by asserting `wr_en` exactly one cycle after a pulse. It then measures the following pulse intervals against the rule that the transfer takes the earlier front value and the new ratio arrives one transfer later. A write during the pulse cycle itself is the other close case, and it must take effect one period sooner. The bench also checks that `tc_half` flips precisely in the cycle after each pulse, while the counter reloads in that same cycle.

// File: rtl/ratio_divider_pkg.sv
package ratio_divider_pkg;
    // Default width of the ratio word and the smallest usable ratio
    localparam int RATIO_W_DEF   = 15;
    localparam int MIN_RATIO_DEF = 17;
endpackage

// File: rtl/ratio_hold.sv
// Front/back ratio registers. Front captures writes at any time; back copies
// the front value (raised to the minimum) only on the transfer strobe.
module ratio_hold #(
    parameter int W   = ratio_divider_pkg::RATIO_W_DEF,
    parameter int MIN = ratio_divider_pkg::MIN_RATIO_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_ratio,
    input  logic         xfer,
    output logic [W-1:0] active_ratio
);
    localparam logic [W-1:0] MIN_V = W'(MIN);

    typedef struct packed {
        logic [W-1:0] front;
        logic [W-1:0] back;
    } hold_t;

    hold_t st_d, st_q;
    logic [W-1:0] front_floor;

    always_comb begin
        st_d        = st_q;
        front_floor = (st_q.front < MIN_V) ? MIN_V : st_q.front;
        if (wr_en) begin
            st_d.front = wr_ratio;
        end
        if (xfer) begin
            st_d.back = front_floor;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.front <= MIN_V;
            st_q.back  <= MIN_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_ratio = st_q.back;

    AST_BACK_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(active_ratio)); // R5
    AST_BACK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        active_ratio >= MIN_V); // R6
endmodule

// File: rtl/ratio_counter.sv
// Presettable down counter with terminal-count detect and the transfer
// strobe that follows each terminal count by one cycle.
module ratio_counter #(
    parameter int W   = ratio_divider_pkg::RATIO_W_DEF,
    parameter int MIN = ratio_divider_pkg::MIN_RATIO_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload_ratio,
    output logic         tc,
    output logic         xfer
);
    localparam logic [W-1:0] START_V = W'(MIN - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         xfer;
    } cnt_t;

    cnt_t st_d, st_q;
    logic at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        if (at_zero) begin
            st_d.cnt = reload_ratio - 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.xfer = at_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= START_V;
            st_q.xfer <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc   = at_zero && rst_n;
    assign xfer = st_q.xfer;

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc); // R2
    AST_XFER_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> $past(tc)); // R3
endmodule

// File: rtl/half_rate.sv
// Toggle flop: terminal-count rate divided by two.
module half_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic tc,
    output logic half
);
    typedef struct packed {
        logic tog;
    } half_t;

    half_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tc) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tog <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half = st_q.tog;
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
    parameter int W   = ratio_divider_pkg::RATIO_W_DEF,
    parameter int MIN = ratio_divider_pkg::MIN_RATIO_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_ratio,
    output logic         tc_pulse,
    output logic         tc_half
);
    logic [W-1:0] active_ratio;
    logic         xfer;

    ratio_hold #(.W(W), .MIN(MIN)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_ratio     (wr_ratio),
        .xfer         (xfer),
        .active_ratio (active_ratio)
    );

    ratio_counter #(.W(W), .MIN(MIN)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_ratio (active_ratio),
        .tc           (tc_pulse),
        .xfer         (xfer)
    );

    half_rate u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .tc    (tc_pulse),
        .half  (tc_half)
    );

    AST_HALF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> (tc_half != $past(tc_half))); // R9
    AST_HALF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_pulse |=> $stable(tc_half)); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!tc_pulse && !tc_half)); // R1
endmodule

// File: tb/ratio_divider_test.sv
`timescale 1ns/1ps
module ratio_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_ratio = '0;
    logic        tc_pulse;
    logic        tc_half;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit mon_on = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    ratio_divider uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ratio (wr_ratio),
        .tc_pulse (tc_pulse),
        .tc_half  (tc_half)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!tc_pulse);
    endtask

    task automatic write_ratio(input int v);
        wr_en    = 1'b1;
        wr_ratio = 15'(v);
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    // Monitor: measure pulse spacing and width, compare against queue
    int cyc = 0;
    int last_pulse = -1;
    bit prev_pulse = 1'b0;
    bit prev_half  = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (prev_pulse) begin
                check(tc_half != prev_half, "R9 half flips after pulse", int'(tc_half), int'(!prev_half));
                check(!tc_pulse, "R2 pulse width one cycle", int'(tc_pulse), 0);
            end else if (tc_half != prev_half) begin
                check(1'b0, "R9 half stable between pulses", int'(tc_half), int'(prev_half));
            end
            if (tc_pulse) begin
                if (last_pulse >= 0) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected pulse", cyc - last_pulse, 0);
                    end else begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check((cyc - last_pulse) == e, t, cyc - last_pulse, e);
                    end
                end
                last_pulse = cyc;
            end
            prev_pulse = tc_pulse;
            prev_half  = tc_half;
        end
    end

    // Driver: called at the negedge of a pulse whose following interval is queued.
    int cur = 17;
    task automatic change(input int n, input int off, input int n2, input int off2, input string tag);
        int last_v;
        int eff;
        repeat (off) @(negedge clk);
        write_ratio(n);
        last_v = n;
        if (off2 > off) begin
            repeat (off2 - off - 1) @(negedge clk);
            write_ratio(n2);
            last_v = n2;
        end
        eff = (last_v < 17) ? 17 : last_v;
        if (off == 0 && off2 <= off) push(eff, {tag, " (pulse-cycle write)"});
        else                         push(cur, "R5 period after write keeps old ratio");
        wait_pulse();
        wait_pulse();
        push(eff, tag);
        cur = eff;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!tc_pulse, "R1 reset pulse low", int'(tc_pulse), 0);
        check(!tc_half, "R1 reset half low", int'(tc_half), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        wait_pulse();
        push(17, "R1 default ratio 17");
        change(40, 0, 0, -1, "R3 ratio 40");
        change(25, 1, 0, -1, "R4 write on transfer edge");
        change(5, 4, 0, -1, "R6 ratio 5 clamps to 17");
        change(0, 3, 0, -1, "R6 ratio 0 clamps to 17");
        change(16, 0, 0, -1, "R6 ratio 16 clamps to 17");
        change(63, 2, 0, -1, "R2 ratio 63");
        change(90, 3, 100, 6, "R8 last write wins");
        change(32767, 2, 0, -1, "R7 max ratio");
        change(18, 2, 0, -1, "R2 ratio 18");
        wait_pulse();
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected periods seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule